// File: doc/BRIEF.md
# Bitmask Immediate Encoder

This block searches for the compact three-field form (a size flag, a rotate count and a run field) that an ALU logical-immediate decoder expands back into a 32- or 64-bit constant. A caller pulses `start` with the constant and a width flag. A few cycles later `done` pulses for one cycle. At that point the outputs either hold the three fields with `encodable` high, or all read zero with `encodable` low. The block does not build the complete instruction word.

The search runs one cycle per candidate element size, from 2 bits up to 64. It stops at the first size for which the constant is an exact repetition of its low element. At that size it checks that each element holds a single run of ones under rotation. It then takes the rotation from the start of that run, and the run field from the population count. The rotation is found on the full 64-bit value, so patterns whose run wraps across bit 63 get the right count.

Top module: `bitmask_imm_enc`

## Requirements
- R1: After reset, `done`, `encodable`, `n_out`, `immr` and `imms` are all zero.
- R2: Every accepted `start` gives exactly one `done` pulse, one cycle wide, within 7 cycles.
- R3: A value of all zeros, or all ones in the selected width, gives `encodable` = 0.
- R4: With `is64` = 0, any value with a bit set in [63:32] is rejected. Otherwise the low 32 bits are encoded with elements of 32 bits or less, and `n_out` is always 0.
- R5: A value whose element is not one circularly contiguous run of ones is rejected, for example 64-bit 0x1234.
- R6: The smallest element size E (2, 4, 8, 16, 32 or 64) whose repetition equals the value is used. `n_out` = 1 only when E = 64. `imms` is (0x3F AND NOT(2E-1)) OR (ones per element - 1), for example 0x3C for 0x5555555555555555.
- R7: `immr` = (E - p) mod E, where p is the bit at which the run begins, found on the full 64-bit value. For example, 0x8000000000000001 gives `immr` = 1, `imms` = 1, `n_out` = 1.
- R8: Decoding the produced fields reproduces the input. Size E is taken from the highest set bit of {`n_out`, NOT `imms`}. A run of (`imms` mod E)+1 ones is rotated right by `immr` mod E, then repeated to the full width.
- R9: When the value is not encodable, `n_out`, `immr` and `imms` are zero at the `done` pulse.
- R10: The outputs keep their values until the next `done`. A `start` that arrives while a search is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search on `value` |
| value | input | 64 | Constant to encode |
| is64 | input | 1 | 1 = 64-bit width, 0 = 32-bit width |
| done | output | 1 | One-cycle result strobe |
| encodable | output | 1 | Result fields are valid |
| n_out | output | 1 | Size flag, set for a 64-bit element |
| immr | output | 6 | Rotate count |
| imms | output | 6 | Element-size prefix and run length minus one |

## Verification
The block has no parameters: the width is fixed at 64 bits with a 32-bit mode, so the bench builds the only configuration there is. That configuration covers every element size from 2 to 64. The stimulus includes runs that wrap across bit 63 with zeros in the upper half, values that are only valid in the 32-bit mode, and rejects for each reason. Every accepted result is also expanded by an independent decoder in the bench and compared with the input.

// File: rtl/bitmask_imm_enc.sv
module bitmask_imm_enc (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [63:0] value,
  input  logic        is64,
  output logic        done,
  output logic        encodable,
  output logic        n_out,
  output logic [5:0]  immr,
  output logic [5:0]  imms
);

  logic        busy;
  logic [2:0]  k;
  logic [63:0] v;
  logic        bad;
  logic        m64;

  logic [6:0]  esize;
  logic        periodic;
  logic [63:0] starts;
  logic [6:0]  nstarts;
  logic [6:0]  ones;
  logic [6:0]  run;
  logic [5:0]  p;
  logic [6:0]  rot7;
  logic [6:0]  sfield7;
  logic        ok;

  assign esize    = 7'd1 << k;
  assign periodic = (v == ((v >> esize) | (v << (7'd64 - esize))));
  assign starts   = v & ~{v[62:0], v[63]};
  assign nstarts  = 7'($countones(starts));
  assign ones     = 7'($countones(v));
  assign run      = ones >> (3'd6 - k);
  assign rot7     = (esize - {1'b0, p}) & (esize - 7'd1);
  assign sfield7  = (7'h3f & ~((esize << 1) - 7'd1)) | (run - 7'd1);
  assign ok       = !bad && (v != 64'd0) && (v != {64{1'b1}}) &&
                    (nstarts == (7'd64 >> k));

  always_comb begin
    p = 6'd0;
    for (int i = 63; i >= 0; i--)
      if (starts[i]) p = 6'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; k <= 3'd1; v <= 64'd0; bad <= 1'b0; m64 <= 1'b0;
      done <= 1'b0; encodable <= 1'b0; n_out <= 1'b0; immr <= 6'd0; imms <= 6'd0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          k    <= 3'd1;
          m64  <= is64;
          bad  <= !is64 && (value[63:32] != 32'd0);
          v    <= is64 ? value : {value[31:0], value[31:0]};
        end
      end else if (periodic || k == 3'd6) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        encodable <= ok;
        n_out     <= ok && (k == 3'd6);
        immr      <= ok ? rot7[5:0] : 6'd0;
        imms      <= ok ? sfield7[5:0] : 6'd0;
      end else begin
        k <= k + 3'd1;
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_REJECT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !encodable) |-> (!n_out && immr == 6'd0 && imms == 6'd0)); // R9

  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({encodable, n_out, immr, imms})); // R10

  AST_NARROW_NO_N: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !m64) |-> !n_out); // R4

  AST_IMMS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && encodable && !n_out) |-> (imms[5:1] != 5'h1f)); // R6

endmodule

// File: tb/bitmask_imm_enc_test.sv
module bitmask_imm_enc_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] value = 64'd0;
  logic        is64 = 1'b1;
  logic        done, encodable, n_out;
  logic [5:0]  immr, imms;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bitmask_imm_enc uut (
    .clk(clk), .rst_n(rst_n), .start(start), .value(value), .is64(is64),
    .done(done), .encodable(encodable), .n_out(n_out), .immr(immr), .imms(imms)
  );

  localparam int NV = 18;
  // {value, is64, ok, n, immr, imms}
  localparam logic [78:0] VEC [NV] = '{
    {64'h8000000000000001, 1'b1, 1'b1, 1'b1, 6'd1,  6'd1 },
    {64'h5555555555555555, 1'b1, 1'b1, 1'b0, 6'd0,  6'h3c},
    {64'hAAAAAAAAAAAAAAAA, 1'b1, 1'b1, 1'b0, 6'd1,  6'h3c},
    {64'h00000000000000FF, 1'b1, 1'b1, 1'b1, 6'd0,  6'd7 },
    {64'hFFFFFFFF00000000, 1'b1, 1'b1, 1'b1, 6'd32, 6'd31},
    {64'h0000000100000000, 1'b1, 1'b1, 1'b1, 6'd32, 6'd0 },
    {64'h00000000000000FF, 1'b0, 1'b1, 1'b0, 6'd0,  6'd7 },
    {64'h0000000080000001, 1'b0, 1'b1, 1'b0, 6'd1,  6'd1 },
    {64'h0F0F0F0F0F0F0F0F, 1'b1, 1'b1, 1'b0, 6'd0,  6'h33},
    {64'h8001800180018001, 1'b1, 1'b1, 1'b0, 6'd1,  6'h21},
    {64'h3333333333333333, 1'b1, 1'b1, 1'b0, 6'd0,  6'h39},
    {64'h7FFFFFFFFFFFFFFF, 1'b1, 1'b1, 1'b1, 6'd0,  6'h3e},
    {64'h0000000000000000, 1'b1, 1'b0, 1'b0, 6'd0,  6'd0 },
    {64'hFFFFFFFFFFFFFFFF, 1'b1, 1'b0, 1'b0, 6'd0,  6'd0 },
    {64'h0000000000001234, 1'b1, 1'b0, 1'b0, 6'd0,  6'd0 },
    {64'h0000000100000000, 1'b0, 1'b0, 1'b0, 6'd0,  6'd0 },
    {64'h00000000FFFFFFFF, 1'b0, 1'b0, 1'b0, 6'd0,  6'd0 },
    {64'h0000000000000000, 1'b0, 1'b0, 1'b0, 6'd0,  6'd0 }
  };

  function automatic logic [63:0] expand(logic nn, logic [5:0] rr, logic [5:0] ss, logic w64);
    logic [6:0]  key;
    int          len, es, sv, rv;
    logic [63:0] res;
    key = {nn, ~ss};
    len = 0;
    for (int i = 0; i < 7; i++) if (key[i]) len = i + 1;
    es  = 1 << (len - 1);
    sv  = int'(ss) % es;
    rv  = int'(rr) % es;
    res = 64'd0;
    for (int i = 0; i < 64; i++) res[i] = (((i % es) + rv) % es) <= sv;
    if (!w64) res[63:32] = 32'd0;
    return res;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(logic [63:0] val, logic w64, output int lat);
    @(negedge clk);
    value = val; is64 = w64; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {59'd0, done, encodable, n_out, (immr != 0), (imms != 0)}, 64'd0);
    rst_n = 1'b1;

    for (int t = 0; t < NV; t++) begin
      logic [78:0] e;
      e = VEC[t];
      run(e[78:15], e[14], lat);
      check("R2 done", {63'd0, done}, 64'd1);
      check("R2 latency", 64'(lat <= 7), 64'd1);
      // R3 R4 R5 R6 R7 R9: fields and flag
      check(e[13] ? "R6 R7 fields" : "R3 R4 R5 R9 reject",
            {50'd0, encodable, n_out, immr, imms}, {50'd0, e[13:0]});
      if (e[13])
        check("R8 round trip", expand(n_out, immr, imms, e[14]),
              e[14] ? e[78:15] : {32'd0, e[46:15]});
      if (!e[14]) check("R4 no N", {63'd0, n_out}, 64'd0);
      @(negedge clk);
      check("R2 pulse", {63'd0, done}, 64'd0);
      check("R10 hold", {50'd0, encodable, n_out, immr, imms}, {50'd0, e[13:0]});
    end

    // R10: start during busy is ignored
    @(negedge clk);
    value = 64'h8000000000000001; is64 = 1'b1; start = 1'b1;
    @(negedge clk);
    value = 64'h5555555555555555; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check("R10 busy ignore", {50'd0, encodable, n_out, immr, imms},
          {50'd0, 1'b1, 1'b1, 6'd1, 6'd1});
    repeat (10) begin
      @(negedge clk);
      check("R10 no extra done", {63'd0, done}, 64'd0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule